// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block paces the scan of a TFT panel. From two packed 32-bit timing words, one for the horizontal axis and one for the vertical axis, it builds three signals: an active-high horizontal sync, an active-high vertical sync and a data-enable. It also gives the current column and row counts, a single-cycle pulse when each frame begins, and a single-cycle pulse when vertical sync begins. It runs at one pixel per clock. Pixel fetch, colour handling, clock generation and panel power are handled by the surrounding logic.

Software writes a timing word through a one-cycle write strobe. A select bit chooses which axis the word is for. A written word is held in a staging register. It is copied into the working timing only when a new frame begins, so a frame never mixes two settings. A level-sensitive enable starts the scan. Dropping the enable stops the scan, clears both counters and silences every output.

Each axis runs through four regions in a fixed order: active region, then front porch, then sync, then back porch. The two axes store their lengths with different offsets. The horizontal active width is stored in units of 16 pixels.

Top module: `raster_tgen`

## Requirements
- R1: After synchronous reset, every output is 0: hsync, vsync, de, frame_start, vsync_evt, px_x and px_y.
- R2: The horizontal word's bits [7:2] hold a width code. The active region lasts (code+1)*16 clocks per line. Bits [1:0] are ignored.
- R3: In the horizontal word, sync width is in bits [15:8], front porch in [23:16] and back porch in [31:24]. Each is stored as its length minus one. A line is therefore active + all three fields + 3 clocks long.
- R4: In the vertical word, bits [9:0] hold the active line count minus one and bits [15:10] hold the sync line count minus one. Front porch in [23:16] and back porch in [31:24] hold plain line counts, and zero is allowed. A frame is therefore all four fields + 2 lines long.
- R5: On both axes the regions come in this order: active, front porch, sync, back porch. hsync is high only during the horizontal sync region. vsync is high for every clock of the lines in the vertical sync region.
- R6: de is high exactly when both the column and the row are inside their active regions.
- R7: frame_start is high for one clock, the clock at column 0 of row 0, once in every frame.
- R8: vsync_evt is high for one clock, the first clock of the first vertical sync line. It coincides with the rise of vsync.
- R9: cfg_sel 0 writes the horizontal word and cfg_sel 1 writes the vertical word, on a clock with cfg_we high. A write made during a frame, including in its final clock, does not change that frame. It governs the frame that follows.
- R10: One clock after scan_en is seen low, px_x and px_y are 0 and all other outputs are low, and they stay so while scan_en is low. The first clock after scan_en is seen high is a frame start that uses the latest written words.
- R11: px_x counts clocks from the start of the line, from 0 to line length − 1. px_y counts lines from the start of the frame, from 0 to frame height − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Scan runs while high |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_sel | input | 1 | Word select: 0 horizontal, 1 vertical |
| cfg_wdata | input | 32 | Timing word |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| px_x | output | 12 | Column counter |
| px_y | output | 12 | Row counter |
| frame_start | output | 1 | One-clock pulse at column 0, row 0 |
| vsync_evt | output | 1 | One-clock pulse at vertical sync start |

## Verification
The collision that matters is between a timing write and the handover of staged timing at the frame boundary. Both can land on the same clock edge. The bench provokes this by writing the horizontal word on the second-to-last clock of a frame and the vertical word on the very last clock. It passes only if the next frame follows the new timing cycle for cycle, while the frame carrying the writes still follows the old timing to its end. A companion scenario writes mid-frame instead. A third scenario drops the enable mid-frame and reprograms while idle, which covers the handover taken on the restart path.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int CW = 12;          // counter / position width
    localparam int WW = 32;          // timing word width
    localparam int HUNIT_LG = 4;     // horizontal active unit = 2**HUNIT_LG pixels

    typedef logic [CW-1:0] pos_t;
    typedef logic [WW-1:0] word_t;

    typedef enum logic {
        SEL_HORZ = 1'b0,
        SEL_VERT = 1'b1
    } cfg_sel_e;

    typedef enum logic [1:0] {
        PH_ACTIVE,
        PH_FRONT,
        PH_SYNC,
        PH_BACK
    } phase_e;

    // region boundaries of one axis, as positions from the axis origin
    typedef struct packed {
        pos_t act_end;
        pos_t sync_beg;
        pos_t sync_end;
        pos_t total;
    } axis_tm_t;

    typedef struct packed {
        axis_tm_t h;
        axis_tm_t v;
    } frame_tm_t;

    function automatic axis_tm_t lay_out(pos_t act, pos_t fp, pos_t sw, pos_t bp);
        axis_tm_t t;
        t.act_end  = act;
        t.sync_beg = act + fp;
        t.sync_end = t.sync_beg + sw;
        t.total    = t.sync_end + bp;
        return t;
    endfunction

    // horizontal: width in 16-pixel units, every field stored minus one
    function automatic axis_tm_t decode_horz(word_t w);
        pos_t act;
        pos_t fp;
        pos_t sw;
        pos_t bp;
        act = pos_t'({w[7:2], {HUNIT_LG{1'b0}}}) + pos_t'(1 << HUNIT_LG);
        sw  = pos_t'(w[15:8])  + pos_t'(1);
        fp  = pos_t'(w[23:16]) + pos_t'(1);
        bp  = pos_t'(w[31:24]) + pos_t'(1);
        return lay_out(act, fp, sw, bp);
    endfunction

    // vertical: active and sync minus one, porches stored as-is
    function automatic axis_tm_t decode_vert(word_t w);
        pos_t act;
        pos_t fp;
        pos_t sw;
        pos_t bp;
        act = pos_t'(w[9:0])   + pos_t'(1);
        sw  = pos_t'(w[15:10]) + pos_t'(1);
        fp  = pos_t'(w[23:16]);
        bp  = pos_t'(w[31:24]);
        return lay_out(act, fp, sw, bp);
    endfunction

    function automatic phase_e phase_of(pos_t p, axis_tm_t t);
        if (p < t.act_end)       return PH_ACTIVE;
        else if (p < t.sync_beg) return PH_FRONT;
        else if (p < t.sync_end) return PH_SYNC;
        else                     return PH_BACK;
    endfunction

endpackage

// File: rtl/raster_cfg.sv
module raster_cfg
    import raster_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  logic      sel,
    input  word_t     wdata,
    input  logic      reload,
    output frame_tm_t tm
);

    word_t     hw_q, vw_q;
    word_t     hw_n, vw_n;
    frame_tm_t tm_q;

    // next staged words; the handover reads these so a write on the
    // closing clock of a frame still reaches the following frame
    always_comb begin
        hw_n = hw_q;
        vw_n = vw_q;
        if (we) begin
            if (cfg_sel_e'(sel) == SEL_VERT) vw_n = wdata;
            else                             hw_n = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_q   <= '0;
            vw_q   <= '0;
            tm_q.h <= decode_horz('0);
            tm_q.v <= decode_vert('0);
        end else begin
            hw_q <= hw_n;
            vw_q <= vw_n;
            if (reload) begin
                tm_q.h <= decode_horz(hw_n);
                tm_q.v <= decode_vert(vw_n);
            end
        end
    end

    assign tm = tm_q;

endmodule

// File: rtl/raster_axis.sv
module raster_axis
    import raster_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    input  logic wrap,
    output pos_t cnt
);

    pos_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= wrap ? '0 : cnt_q + pos_t'(1);
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/raster_out.sv
module raster_out
    import raster_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  pos_t      hcnt,
    input  pos_t      vcnt,
    input  frame_tm_t tm,
    output logic      line_end,
    output logic      frame_last,
    output logic      hsync,
    output logic      vsync,
    output logic      de,
    output logic      frame_start,
    output logic      vsync_evt
);

    phase_e hph;
    phase_e vph;
    logic   col0;

    always_comb begin
        hph        = phase_of(hcnt, tm.h);
        vph        = phase_of(vcnt, tm.v);
        col0       = (hcnt == '0);
        line_end   = (hcnt == tm.h.total - pos_t'(1));
        frame_last = line_end && (vcnt == tm.v.total - pos_t'(1));
        hsync       = run && (hph == PH_SYNC);
        vsync       = run && (vph == PH_SYNC);
        de          = run && (hph == PH_ACTIVE) && (vph == PH_ACTIVE);
        frame_start = run && col0 && (vcnt == '0);
        vsync_evt   = run && col0 && (vcnt == tm.v.sync_beg);
    end

    // R5: active pixels never overlap the horizontal sync region
    p_de_hsync_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(de && hsync));

    // R7: frame start is a single-clock pulse
    p_fs_single_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R8: every rise of vsync carries the event pulse
    p_vs_rise_evt_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> vsync_evt);

endmodule

// File: rtl/raster_tgen.sv
module raster_tgen
    import raster_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          scan_en,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [WW-1:0] cfg_wdata,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] px_x,
    output logic [CW-1:0] px_y,
    output logic          frame_start,
    output logic          vsync_evt
);

    logic      run_q;
    logic      line_end;
    logic      frame_last;
    logic      reload;
    pos_t      hcnt;
    pos_t      vcnt;
    frame_tm_t tm;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= scan_en;
    end

    // working timing refreshes while idle and at each frame boundary
    assign reload = !run_q || frame_last;

    raster_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .reload (reload),
        .tm     (tm)
    );

    raster_axis u_hcnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (!scan_en),
        .adv  (run_q),
        .wrap (line_end),
        .cnt  (hcnt)
    );

    raster_axis u_vcnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (!scan_en),
        .adv  (run_q && line_end),
        .wrap (frame_last),
        .cnt  (vcnt)
    );

    raster_out u_out (
        .clk         (clk),
        .rst         (rst),
        .run         (run_q),
        .hcnt        (hcnt),
        .vcnt        (vcnt),
        .tm          (tm),
        .line_end    (line_end),
        .frame_last  (frame_last),
        .hsync       (hsync),
        .vsync       (vsync),
        .de          (de),
        .frame_start (frame_start),
        .vsync_evt   (vsync_evt)
    );

    assign px_x = hcnt;
    assign px_y = vcnt;

    // R9: working timing is frozen inside a running frame
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (run_q && scan_en && !frame_last) |=> $stable(tm));

    // R10: a clock after the enable is seen low, everything is quiet
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $past(!scan_en) |-> (px_x == '0 && px_y == '0 && !hsync && !vsync
                             && !de && !frame_start && !vsync_evt));

    // R11: column never runs past the line length
    p_x_bound_r11: assert property (@(posedge clk) disable iff (rst)
        px_x < tm.h.total);

endmodule

// File: tb/tb_raster_tgen.sv
`timescale 1ns/1ps
module tb_raster_tgen;

    logic        clk = 1'b0;
    logic        rst;
    logic        scan_en;
    logic        cfg_we;
    logic        cfg_sel;
    logic [31:0] cfg_wdata;
    logic        hsync, vsync, de, frame_start, vsync_evt;
    logic [11:0] px_x, px_y;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    raster_tgen dut (
        .clk(clk), .rst(rst), .scan_en(scan_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .hsync(hsync),
        .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y),
        .frame_start(frame_start), .vsync_evt(vsync_evt)
    );

    // timing words: H {bp, fp, sw, code, 2'bxx}; V {bp, fp, sw, lines}
    localparam logic [31:0] HA = {8'd2, 8'd0, 8'd1, 6'd0, 2'b00}; // 16+1+2+3=22
    localparam logic [31:0] VA = {8'd1, 8'd1, 6'd0, 10'd2};       // 3+1+1+1=6
    localparam logic [31:0] HB = {8'd0, 8'd3, 8'd0, 6'd1, 2'b00}; // 32+4+1+1=38
    localparam logic [31:0] VB = {8'd0, 8'd0, 6'd1, 10'd3};       // 4+0+2+0=6
    localparam logic [31:0] HC = {8'd4, 8'd1, 8'd3, 6'd2, 2'b11}; // 48+2+4+5=59
    localparam logic [31:0] VC = {8'd3, 8'd2, 6'd2, 10'd1};       // 2+2+3+3=10

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_word(input logic sel, input logic [31:0] w);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_scan();
        scan_en = 1'b1;
        @(negedge clk);
    endtask

    // Runs one frame from its first clock, comparing every clock against the
    // requirement arithmetic. Optional writes on clocks ih / iv (-1 = none).
    task automatic run_frame(input logic [31:0] hw, input logic [31:0] vw,
                             input int ih, input logic [31:0] nh,
                             input int iv, input logic [31:0] nv,
                             output int ferr);
        int ha, hs, hf, hb, ht, va, vs, vf, vb, vt;
        int xy_bad, wave_bad, de_line0, hs_line0, hs_first, vs_cnt, vs_first;
        int de_tot, fs_cnt, fs_at, ev_cnt, ev_at, e0;
        ha = (int'(hw[7:2]) + 1) * 16;
        hs = int'(hw[15:8]) + 1;  hf = int'(hw[23:16]) + 1;  hb = int'(hw[31:24]) + 1;
        va = int'(vw[9:0]) + 1;   vs = int'(vw[15:10]) + 1;
        vf = int'(vw[23:16]);     vb = int'(vw[31:24]);
        ht = ha + hf + hs + hb;   vt = va + vf + vs + vb;
        xy_bad = 0; wave_bad = 0; de_line0 = 0; hs_line0 = 0; hs_first = -1;
        vs_cnt = 0; vs_first = -1; de_tot = 0; fs_cnt = 0; fs_at = -1;
        ev_cnt = 0; ev_at = -1;
        e0 = errors;
        for (int c = 0; c < ht * vt; c++) begin
            int x, y;
            bit ehs, evs, ede;
            x = c % ht; y = c / ht;
            ehs = (x >= ha + hf) && (x < ha + hf + hs);
            evs = (y >= va + vf) && (y < va + vf + vs);
            ede = (x < ha) && (y < va);
            if (int'(px_x) != x || int'(px_y) != y) xy_bad++;
            if (hsync != ehs || vsync != evs || de != ede) wave_bad++;
            if (y == 0 && de) de_line0++;
            if (y == 0 && hsync) begin hs_line0++; if (hs_first < 0) hs_first = x; end
            if (vsync) begin vs_cnt++; if (vs_first < 0) vs_first = c; end
            if (de) de_tot++;
            if (frame_start) begin fs_cnt++; fs_at = c; end
            if (vsync_evt) begin ev_cnt++; ev_at = c; end
            if (c == ih) begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = nh; end
            else if (c == iv) begin cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = nv; end
            else cfg_we = 1'b0;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        chk(xy_bad == 0, "R11", "x/y mismatches", xy_bad, 0);
        chk(wave_bad == 0, "R5", "sync/de waveform mismatches", wave_bad, 0);
        chk(de_line0 == ha, "R2", "de clocks in line 0", de_line0, ha);
        chk(hs_line0 == hs && hs_first == ha + hf, "R3", "hsync start column",
            hs_first, ha + hf);
        chk(vs_cnt == vs * ht && vs_first == (va + vf) * ht, "R4", "vsync clocks",
            vs_cnt, vs * ht);
        chk(de_tot == ha * va, "R6", "de clocks per frame", de_tot, ha * va);
        chk(fs_cnt == 1 && fs_at == 0, "R7", "frame_start position", fs_at, 0);
        chk(ev_cnt == 1 && ev_at == (va + vf) * ht, "R8", "vsync_evt position",
            ev_at, (va + vf) * ht);
        ferr = errors - e0;
    endtask

    task automatic t_reset();
        rst = 1'b1; scan_en = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({hsync, vsync, de, frame_start, vsync_evt} == 5'b0, "R1", "pulses after reset",
            int'({hsync, vsync, de, frame_start, vsync_evt}), 0);
        chk(px_x == 0 && px_y == 0, "R1", "counters after reset", int'(px_x), 0);
    endtask

    task automatic t_basic();
        int f;
        write_word(1'b0, HA);
        write_word(1'b1, VA);
        start_scan();
        run_frame(HA, VA, -1, '0, -1, '0, f);
        run_frame(HA, VA, -1, '0, -1, '0, f);   // back-to-back frame, R7 repeat
    endtask

    task automatic t_zero_porch();
        int f;
        scan_en = 1'b0;
        @(negedge clk);
        write_word(1'b0, HB);
        write_word(1'b1, VB);
        start_scan();
        run_frame(HB, VB, -1, '0, -1, '0, f);
        chk(f == 0, "R4", "zero vertical porches frame", f, 0);
    endtask

    task automatic t_shadow_mid();
        int f;
        // B still running; C written mid-frame must wait for the next frame
        run_frame(HB, VB, 40, HC, 77, VC, f);
        chk(f == 0, "R9", "frame carrying mid-frame write kept old timing", f, 0);
        run_frame(HC, VC, -1, '0, -1, '0, f);
        chk(f == 0, "R9", "next frame took new timing, H bits [1:0] ignored", f, 0);
    endtask

    task automatic t_shadow_last();
        int f;
        int tot;
        tot = 59 * 10;
        run_frame(HC, VC, tot - 2, HA, tot - 1, VA, f);
        chk(f == 0, "R9", "frame with writes on its final clocks unchanged", f, 0);
        run_frame(HA, VA, -1, '0, -1, '0, f);
        chk(f == 0, "R9", "write on final clock reached the next frame", f, 0);
    endtask

    task automatic t_disable();
        int f;
        repeat (9) @(negedge clk);
        scan_en = 1'b0;
        @(negedge clk);
        chk({hsync, vsync, de, frame_start, vsync_evt} == 5'b0 && px_x == 0 && px_y == 0,
            "R10", "quiet one clock after disable", int'(px_x), 0);
        write_word(1'b0, HB);
        write_word(1'b1, VB);
        repeat (4) @(negedge clk);
        chk({hsync, vsync, de, frame_start, vsync_evt} == 5'b0 && px_x == 0 && px_y == 0,
            "R10", "still quiet while disabled", int'(px_y), 0);
        start_scan();
        chk(frame_start == 1'b1, "R10", "restart begins with frame start",
            int'(frame_start), 1);
        run_frame(HB, VB, -1, '0, -1, '0, f);
        chk(f == 0, "R10", "restart uses words written while idle", f, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_zero_porch();
        t_shadow_mid();
        t_shadow_last();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule